// File: doc/BRIEF.md
# Write-Once Wiper Store Controller

This block keeps a bank of write-once storage slots for a digital rheostat's wiper code. A store request takes the wiper code presented at that moment and burns it into the next unused slot. Slot 1 is written first, and each later store goes one slot higher. Each store holds a busy flag high for a long, parameterized programming period. While busy is high, other store and read requests are locked out. A status bit reports whether the most recent store completed.

The controller always shows a recall value. This is the contents of the most recently burnt slot, or midscale if no slot has been burnt yet. It also reports the binary number of the last burnt slot, so software can see how much capacity is left. A read port returns any slot selected by a 6-bit index. The slots are modelled as on-chip registers, and reset returns them to the unburnt state.

Top module: `otp_store_ctrl`

## Requirements
- R1: After reset, busy = 0, prog_ok = 0, last_slot = 0, blank = 1, full = 0, rd_data = 0 and recall_code = midscale (2^(DATA_W-1), 512 by default).
- R2: A store is accepted when store_req = 1, store_en = 1, busy = 0 and full = 0 are all sampled on one clock edge. Busy is then high from the next cycle for exactly PROG_CYCLES cycles.
- R3: The first completed store writes slot 1, and each later store writes the slot above the previous one. When a store completes, last_slot steps up by exactly one and reports that slot number in binary.
- R4: prog_ok goes to 1 on the edge that ends a programming period, in the same cycle that busy falls. A refused store request clears it.
- R5: A store request with store_en = 0 starts no programming, leaves last_slot unchanged and clears prog_ok.
- R6: A store request made while busy is high is not queued. Only one slot is written for the original request.
- R7: After SLOTS stores, full = 1. A further store request leaves busy at 0, leaves last_slot at SLOTS, clears prog_ok and changes no slot.
- R8: recall_code equals the contents of slot last_slot. When no slot has been burnt, blank = 1 and recall_code is midscale.
- R9: rd_req with rd_index = i, with busy low, loads rd_data on the next edge. The value is slot i's contents when 1 <= i <= SLOTS. It is zero for index 0, for an index above SLOTS, and for an unburnt slot.
- R10: rd_req while busy is high is ignored, and rd_data keeps its value.
- R11: The stored value is the wiper_code captured when the store was accepted. Changes to wiper_code during the programming period have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| store_en | input | 1 | Store permission; store requests are refused while it is low |
| store_req | input | 1 | Single-cycle request to burn the wiper code |
| wiper_code | input | DATA_W | Current wiper code to be stored |
| rd_req | input | 1 | Single-cycle slot read request |
| rd_index | input | SEL_W | Slot number to read |
| rd_data | output | DATA_W | Result of the last accepted read |
| recall_code | output | DATA_W | Last burnt value, or midscale if none |
| blank | output | 1 | No slot burnt yet |
| last_slot | output | SEL_W | Number of the last burnt slot (0 if none) |
| full | output | 1 | All slots burnt |
| busy | output | 1 | Programming in progress |
| prog_ok | output | 1 | Last store completed successfully |

## Verification
The assertions assume that store_req and rd_req are driven on the falling edge and are known after reset. They also assume a request may arrive in any cycle, including during busy or when the bank is full. The bench drives every input half a period away from the sampling edge. It makes its refused requests deliberately, while busy is high, with store_en low, and after the bank is full, so that each refusal path is exercised. Reset is applied once at the start and is not pulsed during a programming period, because the checks on busy length assume an uninterrupted count.

// File: rtl/otp_store_pkg.sv
package otp_store_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_PROG = 1'b1
    } prog_state_e;

    // reasons a store request can be refused
    typedef struct packed {
        logic not_enabled;
        logic locked;
        logic exhausted;
    } refuse_t;

    function automatic logic [31:0] midscale_of(input int unsigned width);
        return 32'(1) << (width - 1);
    endfunction

    function automatic logic index_in_bank(input int unsigned idx, input int unsigned slots);
        return (idx >= 1) && (idx <= slots);
    endfunction

endpackage

// File: rtl/otp_prog_timer.sv
module otp_prog_timer #(
    parameter int unsigned PROG_CYCLES = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int unsigned CNT_W = $clog2(PROG_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(PROG_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            cnt  <= LOAD;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    assign done = busy && (cnt == '0);

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != '0) |=> busy);

    // R2
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && cnt == LOAD));

endmodule

// File: rtl/otp_slot_array.sv
module otp_slot_array #(
    parameter int unsigned SLOTS  = 50,
    parameter int unsigned DATA_W = 10,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_val,
    input  logic [ADDR_W-1:0] recall_addr,
    output logic [DATA_W-1:0] recall_val
);
    logic [DATA_W-1:0] mem [SLOTS];
    logic [SLOTS-1:0]  burnt;
    logic              wr_hits_burnt;
    logic              wr_in_bank;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) mem[i] <= '0;
            burnt <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < SLOTS; i++) begin
                if (wr_addr == ADDR_W'(i + 1) && !burnt[i]) begin
                    mem[i]   <= wr_data;
                    burnt[i] <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        rd_val        = '0;
        recall_val    = '0;
        wr_hits_burnt = 1'b0;
        wr_in_bank    = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            if (rd_addr == ADDR_W'(i + 1))     rd_val     = mem[i];
            if (recall_addr == ADDR_W'(i + 1)) recall_val = mem[i];
            if (wr_addr == ADDR_W'(i + 1)) begin
                wr_in_bank    = 1'b1;
                wr_hits_burnt = burnt[i];
            end
        end
    end

    // R3
    write_once_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_in_bank && !wr_hits_burnt));

endmodule

// File: rtl/otp_store_ctrl.sv
module otp_store_ctrl
    import otp_store_pkg::*;
#(
    parameter int unsigned SLOTS       = 50,
    parameter int unsigned DATA_W      = 10,
    parameter int unsigned SEL_W       = 6,
    parameter int unsigned PROG_CYCLES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              store_en,
    input  logic              store_req,
    input  logic [DATA_W-1:0] wiper_code,
    input  logic              rd_req,
    input  logic [SEL_W-1:0]  rd_index,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] recall_code,
    output logic              blank,
    output logic [SEL_W-1:0]  last_slot,
    output logic              full,
    output logic              busy,
    output logic              prog_ok
);
    localparam logic [DATA_W-1:0] MID      = DATA_W'(midscale_of(DATA_W));
    localparam logic [SEL_W-1:0]  TOP_SLOT = SEL_W'(SLOTS);

    prog_state_e       state;
    refuse_t           why;
    logic              accept;
    logic              done;
    logic [DATA_W-1:0] pend_code;
    logic [DATA_W-1:0] arr_rd;
    logic [DATA_W-1:0] arr_recall;
    logic [SEL_W-1:0]  next_slot;

    assign full      = (last_slot == TOP_SLOT);
    assign blank     = (last_slot == '0);
    assign next_slot = last_slot + 1'b1;

    assign why.not_enabled = !store_en;
    assign why.locked      = busy;
    assign why.exhausted   = full;
    assign accept          = store_req && (why == '0);

    otp_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .busy  (busy),
        .done  (done)
    );

    otp_slot_array #(.SLOTS(SLOTS), .DATA_W(DATA_W), .ADDR_W(SEL_W)) u_bank (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (done),
        .wr_addr     (next_slot),
        .wr_data     (pend_code),
        .rd_addr     (rd_index),
        .rd_val      (arr_rd),
        .recall_addr (last_slot),
        .recall_val  (arr_recall)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            pend_code <= '0;
            last_slot <= '0;
            prog_ok   <= 1'b0;
        end else begin
            if (accept) begin
                state     <= ST_PROG;
                pend_code <= wiper_code;
                prog_ok   <= 1'b0;
            end else if (store_req) begin
                prog_ok <= 1'b0;
            end
            if (done) begin
                state     <= ST_IDLE;
                last_slot <= next_slot;
                prog_ok   <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                  rd_data <= '0;
        else if (rd_req && !busy) rd_data <= index_in_bank(32'(rd_index), SLOTS) ? arr_rd : '0;
    end

    assign recall_code = blank ? MID : arr_recall;

    // R3
    slot_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(last_slot) |-> (last_slot == $past(last_slot) + 1'b1));

    // R4
    ok_with_end_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(prog_ok) |-> $fell(busy));

    // R5
    no_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (store_req && !store_en && !busy) |=> !busy);

    // R7
    full_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (store_req && full && !busy) |=> (!busy && !prog_ok && full));

    // R10
    rd_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && busy) |=> $stable(rd_data));

    // R2
    state_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PROG) == busy);

endmodule

// File: tb/sim_otp_store_ctrl.sv
module sim_otp_store_ctrl;
    localparam int CLK_P  = 10;
    localparam int SLOTS  = 50;
    localparam int DW     = 10;
    localparam int SW     = 6;
    localparam int PROG   = 32;
    localparam int MID    = 512;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          store_en = 1'b0, store_req = 1'b0, rd_req = 1'b0;
    logic [DW-1:0] wiper_code = '0;
    logic [SW-1:0] rd_index = '0;
    logic [DW-1:0] rd_data, recall_code;
    logic          blank, full, busy, prog_ok;
    logic [SW-1:0] last_slot;

    int n_chk = 0, n_bad = 0;
    int model [0:SLOTS];
    int stored = 0;

    always #(CLK_P/2) clk = ~clk;

    otp_store_ctrl #(.SLOTS(SLOTS), .DATA_W(DW), .SEL_W(SW), .PROG_CYCLES(PROG)) u0 (
        .clk(clk), .rst(rst), .store_en(store_en), .store_req(store_req),
        .wiper_code(wiper_code), .rd_req(rd_req), .rd_index(rd_index),
        .rd_data(rd_data), .recall_code(recall_code), .blank(blank),
        .last_slot(last_slot), .full(full), .busy(busy), .prog_ok(prog_ok)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 busy", busy, 0);
        chk("R1 prog_ok", prog_ok, 0);
        chk("R1 last_slot", last_slot, 0);
        chk("R1 blank", blank, 1);
        chk("R1 full", full, 0);
        chk("R1 rd_data", rd_data, 0);
        chk("R1 recall", recall_code, MID);
    endtask

    task automatic do_read(input int idx, input int exp, input string req);
        rd_req = 1'b1; rd_index = SW'(idx);
        tick();
        rd_req = 1'b0;
        chk(req, rd_data, exp);
    endtask

    // store one code; when poke is set, disturb inputs during busy (R6, R10, R11)
    task automatic do_store(input int code, input bit poke);
        int n;
        int prev;
        prev = last_slot;
        store_en = 1'b1; store_req = 1'b1; wiper_code = DW'(code);
        tick();
        store_req = 1'b0;
        chk("R2 busy after accept", busy, 1);
        n = 0;
        if (poke) begin
            wiper_code = ~DW'(code);
            store_req = 1'b1; rd_req = 1'b1; rd_index = SW'(1);
            model[0] = rd_data;
            tick(); n++;
            store_req = 1'b0; rd_req = 1'b0;
            chk("R10 rd_data held", rd_data, model[0]);
            chk("R6 prog_ok during busy", prog_ok, 0);
        end
        while (busy && n < PROG + 8) begin
            tick(); n++;
        end
        chk("R2 busy length", n, PROG);
        chk("R4 prog_ok set", prog_ok, 1);
        chk("R3 slot step", last_slot, prev + 1);
        stored++;
        model[stored] = code;
        chk("R11/R8 recall value", recall_code, code);
    endtask

    task automatic t_disabled;
        store_en = 1'b0; store_req = 1'b1; wiper_code = 10'h155;
        tick();
        store_req = 1'b0;
        chk("R5 no busy", busy, 0);
        chk("R5 prog_ok cleared", prog_ok, 0);
        chk("R5 last_slot kept", last_slot, stored);
    endtask

    task automatic t_full;
        chk("R7 full", full, 1);
        chk("R7 prog_ok before", prog_ok, 1);
        store_en = 1'b1; store_req = 1'b1; wiper_code = 10'h0F0;
        tick();
        store_req = 1'b0;
        chk("R7 no busy", busy, 0);
        chk("R7 prog_ok cleared", prog_ok, 0);
        chk("R7 last_slot", last_slot, SLOTS);
        tick();
        chk("R7 still idle", busy, 0);
        chk("R7/R8 recall unchanged", recall_code, model[SLOTS]);
        do_read(SLOTS, model[SLOTS], "R7 top slot unchanged");
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i <= SLOTS; i++) model[i] = 0;
        @(negedge clk); tick(); tick();
        rst = 1'b0;
        tick();
        t_reset();
        do_read(1, 0, "R9 unburnt slot");
        do_read(0, 0, "R9 index zero");
        t_disabled();
        do_store(10'h2A5, 1'b0);
        chk("R8 blank cleared", blank, 0);
        do_read(1, 10'h2A5, "R9 slot 1");
        t_disabled();
        do_read(2, 0, "R9 slot 2 unburnt");
        do_store(10'h0C3, 1'b1);
        do_read(2, 10'h0C3, "R11 captured code");
        for (int k = 3; k <= SLOTS; k++) do_store((k * 37 + 5) & 10'h3FF, 1'b0);
        t_full();
        do_read(25, model[25], "R9 slot 25");
        do_read(SLOTS + 1, 0, "R9 index above bank");
        do_read(63, 0, "R9 index 63");
        do_read(1, 10'h2A5, "R3 slot 1 first");
        finish_run();
    end
endmodule